// File: doc/BRIEF.md
# PSK Carrier Phase Error Detector

This block turns the phase angle of a received symbol into a carrier phase error by removing the M-ary PSK modulation. The phase arrives as an unsigned binary angle covering one full turn. It is first rotated by a coarse programmable offset, which is added to the upper bits only. It is then multiplied by a power of two with a wrap-around left shift. After these two steps every ideal constellation point lands on angle zero. The result is a signed error folded into an arc centred on zero, and a carrier recovery loop filter that follows can use it directly.

The offset and shift come from a plain configuration word. Four of its bits hold the signed offset in steps of one sixteenth of a turn. Two of its bits hold the shift count. Samples flow through a single registered stage with a valid/ready handshake:

- A sample moves when `in_valid` and `in_ready` are both high at a rising clock edge.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- A result held while `out_ready` is low stays unchanged until it is taken.
- The configuration word is sampled together with the phase at acceptance, so a change affects the next accepted sample only.

Top module: `psk_phase_err`

## Requirements
- R1: While `rst_n` is low and after it is released, `out_valid` is 0 until a sample has been accepted.
- R2: `cfg_word[3:0]` is a 4-bit two's complement offset added to `in_phase[7:4]`, with the carry discarded. `in_phase[3:0]` is not changed by the rotation, so with a shift of 0, `out_err[3:0]` equals the accepted `in_phase[3:0]`.
- R3: `cfg_word[5:4]` gives a left shift of 0 to 3 positions on the rotated phase. Bits leaving the MSB are dropped and zeros enter the LSBs, so with a shift of 3, `out_err[2:0]` is 0.
- R4: With `cfg_word` equal to 0, `out_err` equals the accepted `in_phase`.
- R5: With offset 2 and shift 2 (`cfg_word`=0x22, QPSK), the ideal phases 0x20, 0x60, 0xA0 and 0xE0 give 0x00. An added error e gives 4·e modulo 256.
- R6: With offset 4 and shift 1 (`cfg_word`=0x14, BPSK), the ideal phases 0x40 and 0xC0 give 0x00. An added error e gives 2·e modulo 256.
- R7: With offset 1 and shift 3 (`cfg_word`=0x31, 8PSK), the ideal phases 0x10+0x20·k give 0x00. An added error e gives 8·e modulo 256.
- R8: A negative offset rotates backwards with wrap-around. For example, offset 0xF with shift 0 maps phase 0x05 to 0xF5.
- R9: `in_ready` equals NOT `out_valid` OR `out_ready`. A sample is accepted exactly when `in_valid` and `in_ready` are both high at a rising edge. `out_valid` is high in the next cycle, and it goes low after a drain that has no new sample.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_err` stay unchanged, even if `cfg_word` or `in_phase` change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 6 | [3:0] signed offset, [5:4] shift count |
| in_valid | input | 1 | Input phase is valid |
| in_ready | output | 1 | Block can accept a phase |
| in_phase | input | 8 | Unsigned phase, one full turn = 256 |
| out_valid | output | 1 | Output error is valid |
| out_ready | input | 1 | Consumer takes the error |
| out_err | output | 8 | Signed folded phase error |

## Verification
The bench builds the block with its default parameters: an 8-bit phase, a 4-bit offset and a 2-bit shift count. With these values, all 64 configuration codes and all 256 phases can be reached by random stimulus, as can every carry and drop-out position of the shift. Directed samples place ideal QPSK, BPSK and 8PSK points plus known errors on the input. They also cover negative offsets and wrap-around, and a configuration change during a stall. Random valid and ready patterns exercise the back-pressure timing.

// File: rtl/psk_phase_err_pkg.sv
package psk_phase_err_pkg;
  localparam int unsigned PH_W_DEF  = 8;
  localparam int unsigned OFS_W_DEF = 4;
  localparam int unsigned SH_W_DEF  = 2;

  typedef struct packed {
    logic [SH_W_DEF-1:0]  shamt;
    logic [OFS_W_DEF-1:0] offset;
  } pe_cfg_t;

  function automatic pe_cfg_t pe_cfg_split(input logic [SH_W_DEF+OFS_W_DEF-1:0] w);
    pe_cfg_t c;
    c.offset = w[OFS_W_DEF-1:0];
    c.shamt  = w[SH_W_DEF+OFS_W_DEF-1:OFS_W_DEF];
    return c;
  endfunction
endpackage

// File: rtl/pe_rotate.sv
module pe_rotate #(
  parameter int unsigned PH_W  = 8,
  parameter int unsigned OFS_W = 4
) (
  input  logic [PH_W-1:0]  phase_i,
  input  logic [OFS_W-1:0] offset_i,
  output logic [PH_W-1:0]  phase_o
);
  localparam int unsigned LO_W = PH_W - OFS_W;

  generate
    if (LO_W == 0) begin : g_full
      assign phase_o = phase_i + offset_i;
    end else begin : g_upper
      logic [OFS_W-1:0] hi_sum;
      assign hi_sum  = phase_i[PH_W-1 -: OFS_W] + offset_i;
      assign phase_o = {hi_sum, phase_i[LO_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/pe_fold.sv
module pe_fold #(
  parameter int unsigned PH_W = 8,
  parameter int unsigned SH_W = 2
) (
  input  logic [PH_W-1:0] phase_i,
  input  logic [SH_W-1:0] shamt_i,
  output logic [PH_W-1:0] fold_o
);
  logic [PH_W-1:0] stage [SH_W+1];

  assign stage[0] = phase_i;

  generate
    for (genvar k = 0; k < SH_W; k++) begin : g_stage
      assign stage[k+1] = shamt_i[k] ? (stage[k] << (2**k)) : stage[k];
    end
  endgenerate

  assign fold_o = stage[SH_W];
endmodule

// File: rtl/pe_pipe.sv
module pe_pipe #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      if (take) begin
        out_valid <= 1'b1;
        out_data  <= in_data;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  a_r9_accept_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  a_r9_drain_clears_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (out_ready && !in_valid) |=> !out_valid);

  a_r10_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  a_r10_stall_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: rtl/psk_phase_err.sv
module psk_phase_err
  import psk_phase_err_pkg::*;
#(
  parameter int unsigned PH_W  = PH_W_DEF,
  parameter int unsigned OFS_W = OFS_W_DEF,
  parameter int unsigned SH_W  = SH_W_DEF
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [OFS_W+SH_W-1:0] cfg_word,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [PH_W-1:0]       in_phase,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [PH_W-1:0]       out_err
);
  localparam int unsigned LO_W   = PH_W - OFS_W;
  localparam int unsigned MAX_SH = (2**SH_W) - 1;

  logic [OFS_W-1:0] offset;
  logic [SH_W-1:0]  shamt;
  logic [PH_W-1:0]  rotated;
  logic [PH_W-1:0]  folded;

  assign offset = cfg_word[OFS_W-1:0];
  assign shamt  = cfg_word[OFS_W+SH_W-1:OFS_W];

  pe_rotate #(.PH_W(PH_W), .OFS_W(OFS_W)) u_rotate (
    .phase_i  (in_phase),
    .offset_i (offset),
    .phase_o  (rotated)
  );

  pe_fold #(.PH_W(PH_W), .SH_W(SH_W)) u_fold (
    .phase_i (rotated),
    .shamt_i (shamt),
    .fold_o  (folded)
  );

  pe_pipe #(.W(PH_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (folded),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_err)
  );

  // R4: zero configuration passes the phase through one stage later
  a_r4_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && cfg_word == '0) |=> (out_err == $past(in_phase)));

  generate
    if (LO_W > 0) begin : g_lo_chk
      a_r2_low_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && shamt == '0)
          |=> (out_err[LO_W-1:0] == $past(in_phase[LO_W-1:0])));
    end
    if (MAX_SH < PH_W) begin : g_fill_chk
      a_r3_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && shamt == SH_W'(MAX_SH))
          |=> (out_err[MAX_SH-1:0] == '0));
    end
  endgenerate
endmodule

// File: tb/psk_phase_err_tb_top.sv
module psk_phase_err_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] cfg_word = '0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_phase = '0;
  logic       out_valid;
  logic       out_ready = 1'b0;
  logic [7:0] out_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];

  always #10 clk = ~clk;

  psk_phase_err dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word),
    .in_valid(in_valid), .in_ready(in_ready), .in_phase(in_phase),
    .out_valid(out_valid), .out_ready(out_ready), .out_err(out_err)
  );

  function automatic logic [7:0] model(input logic [5:0] c, input logic [7:0] p);
    logic [7:0] r;
    r = {p[7:4] + c[3:0], p[3:0]};
    return r << c[5:4];
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_one(input string tag, input logic [5:0] c,
                          input logic [7:0] p, input logic [7:0] exp);
    @(negedge clk);
    cfg_word = c; in_phase = p; in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check({tag, " valid"}, {7'd0, out_valid}, 8'd1);
    check(tag, out_err, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset valid", {7'd0, out_valid}, 8'd0);
    check("R9 reset ready", {7'd0, in_ready}, 8'd1);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check("R1 idle after reset", {7'd0, out_valid}, 8'd0);

    // R4 passthrough
    send_one("R4 passthrough", 6'h00, 8'hA7, 8'hA7);
    // R2 rotation, low nibble kept
    send_one("R2 rotate", 6'h03, 8'h5C, 8'h8C);
    send_one("R2 carry drop", 6'h07, 8'hE1, 8'h51);
    // R3 shift with drop and zero fill
    send_one("R3 shift1", 6'h10, 8'hC3, 8'h86);
    send_one("R3 shift3", 6'h30, 8'hFF, 8'hF8);
    // R8 negative offset
    send_one("R8 negative", 6'h0F, 8'h05, 8'hF5);
    send_one("R8 neg max", 6'h08, 8'h12, 8'h92);
    // R5 QPSK
    for (int k = 0; k < 4; k++)
      send_one("R5 qpsk ideal", 6'h22, 8'(8'h20 + 8'h40 * k), 8'h00);
    send_one("R5 qpsk +err", 6'h22, 8'h63, 8'h0C);
    send_one("R5 qpsk -err", 6'h22, 8'hDE, 8'hF8);
    // R6 BPSK
    send_one("R6 bpsk ideal0", 6'h14, 8'h40, 8'h00);
    send_one("R6 bpsk ideal1", 6'h14, 8'hC0, 8'h00);
    send_one("R6 bpsk err", 6'h14, 8'hC5, 8'h0A);
    // R7 8PSK
    for (int k = 0; k < 8; k++)
      send_one("R7 8psk ideal", 6'h31, 8'(8'h10 + 8'h20 * k), 8'h00);
    send_one("R7 8psk err", 6'h31, 8'h2F, 8'hF8);

    // R10 stall with config change
    @(negedge clk);
    out_ready = 1'b1;
    @(negedge clk);
    cfg_word = 6'h22; in_phase = 8'h61; in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    in_valid = 1'b1; cfg_word = 6'h3F; in_phase = 8'h00;
    for (int i = 0; i < 4; i++) begin
      #1;
      check("R10 stall ready low", {7'd0, in_ready}, 8'd0);
      check("R10 held value", out_err, 8'h04);
      @(negedge clk);
    end
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk); #1;
    check("R9 drained", {7'd0, out_valid}, 8'd0);

    // random traffic
    begin
      bit         prev_stall = 1'b0;
      logic [7:0] prev_val = '0;
      for (int n = 0; n < 4000; n++) begin
        @(negedge clk);
        cfg_word  = 6'($urandom % 64);
        in_phase  = 8'($urandom % 256);
        in_valid  = ($urandom % 10) < 7;
        out_ready = ($urandom % 4) != 0;
        #1;
        if (prev_stall) begin
          check("R10 random hold valid", {7'd0, out_valid}, 8'd1);
          check("R10 random hold data", out_err, prev_val);
        end
        check("R9 ready rule", {7'd0, in_ready}, {7'd0, (!out_valid || out_ready)});
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check("R9 unexpected output", out_err, 8'hxx);
          else check("R9 random result", out_err, exp_q.pop_front());
        end
        if (in_valid && in_ready) exp_q.push_back(model(cfg_word, in_phase));
        prev_stall = out_valid && !out_ready;
        prev_val   = out_err;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      #1;
      if (out_valid && exp_q.size() != 0) check("R9 final result", out_err, exp_q.pop_front());
      @(negedge clk); #1;
      check("R9 final idle", {7'd0, out_valid}, 8'd0);
      check("R9 queue empty", 8'(exp_q.size()), 8'd0);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule